// File: doc/BRIEF.md
# One-Wire Bus Master

This block is the master side of a single-line, open-drain serial bus. It is operated through four 16-bit registers: a control register, a timebase divider register, a data register and a status register. Software starts a bus operation by setting a command bit in the control register. The bit reads back as 1 while the operation runs and clears itself when the operation ends, so polling it is enough to know the operation has finished.

Three bit-level operations exist. The first is a reset sequence with presence detection. The second is a slot that writes a 0. The third is a slot that writes a 1, and the same slot also reads a bit back. In byte mode, a write to the data register queues eight such slots, least significant bit first. A 0 bit becomes a write-0 slot and a 1 bit becomes a write-1/read slot. The eight sampled levels are collected into a received byte, so writing 0xFF reads one byte from the bus. Four status flags track the transmit buffer, the transmit shifter, the receive buffer and the receive shifter.

All timing is counted in ticks of about one microsecond. The tick is made by dividing the input clock by N, where the divider register holds N-1. The input clock should be 10 MHz or faster. Every duration below is therefore that many multiples of N clock cycles, counted from the clock edge that accepts the command.

Top module: `owm_master`

## Requirements
- R1: After reset, the control register reads 0x0000 and the status register reads 0x000C (both transmit-empty flags set, both receive-full flags clear). The divider reads its default value of 99, and `busLow` is 0.
- R2: The divider register holds N-1, and one tick lasts N clock cycles. The tick counter restarts when an operation is accepted, so a phase of T microseconds lasts exactly T*N cycles.
- R3: Writing control bit 7 pulls the line low for 480 ticks. The block then releases the line, samples it 70 ticks later and waits until 960 ticks in total have passed. Bit 7 reads 1 for exactly those 960 ticks.
- R4: Control bit 6 reads 1 when the line was low at the presence sample point of the latest reset sequence, and 0 when it was high.
- R5: Writing control bit 5 pulls the line low for 60 ticks. The slot, including a 10-tick recovery, lasts 70 ticks, and bit 5 reads 1 for exactly that time.
- R6: Writing control bit 4 pulls the line low for 6 ticks and samples the line 15 ticks into the slot. Bit 4 reads 1 for 70 ticks. Control bit 3 then holds the sampled level.
- R7: If a control write sets several command bits, reset wins over write-0, and write-0 wins over write-1. A control command is ignored while a bit operation or a byte transfer is in progress.
- R8: Writing a byte to the data register (address 2) sends its bits least significant first. Each 0 is sent as a write-0 slot and each 1 as a write-1/read slot.
- R9: The eight sampled levels form the received byte, least significant first. Writing 0xFF returns the slave's byte. When the byte completes, status bit 4 is set. Reading the data register returns the byte and clears bit 4.
- R10: A data write clears status bit 2 (transmit buffer empty) and status bit 3 (transmit shifter empty). Bit 2 is set again once the byte has moved into the shifter. Bit 3 is set after the last bit when no further byte is waiting. A data write while bit 2 is 0 is ignored.
- R11: If a byte completes while status bit 4 is already set, the byte is held and status bit 5 is set. No queued byte starts while bit 5 is set. A data read then returns the older byte, moves the held byte into its place and clears bit 5.
- R12: `busLow` is the only line output. It is 1 only during the low phases given in R3, R5 and R6, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, at least 10 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (has a side effect only on the data register) |
| regAddr | input | 2 | Register select: 0 control, 1 divider, 2 data, 3 status |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the selected register |
| busIn | input | 1 | Level sensed on the bus line |
| busLow | output | 1 | Pull the bus line low when 1; release it when 0 |

## Verification
The bench counts the low time and the command-bit busy time of each operation in clock cycles, at two divider settings. A divider whose counter does not restart, or a slot with a wrong phase length, therefore shows up as an off-by-N count. A slave model drives presence pulses and read bits, and records the bits it receives by their low width. A design that swapped bit order, inverted the presence flag or sampled outside the slave's window would return the wrong byte or the wrong flag. Other corner cases are aimed at directly: a second queued byte followed by an overflow write that must be dropped, a byte that completes while the receive buffer is still full, and commands issued during a busy reset or an active byte. A design that handled these wrongly would show extra slots, lost bytes or command bits that never clear.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;

  typedef enum logic [1:0] {
    SLOT_RST = 2'd0,
    SLOT_W0  = 2'd1,
    SLOT_W1  = 2'd2
  } slotKind_e;

  // control -> engine
  typedef struct packed {
    logic      start;
    slotKind_e kind;
  } slotReq_t;

  // engine -> control
  typedef struct packed {
    logic busy;
    logic smp;
    logic smpBit;
    logic done;
  } slotEvt_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CB_RST   = 7;
  localparam int CB_PRES  = 6;
  localparam int CB_W0    = 5;
  localparam int CB_W1    = 4;
  localparam int CB_RDBIT = 3;

  localparam int SB_TBE  = 2;
  localparam int SB_TSRE = 3;
  localparam int SB_RBF  = 4;
  localparam int SB_RSRF = 5;

endpackage

// File: rtl/owm_slot_engine.sv
`timescale 1ns/1ps
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_RST_WAIT  = 410,
  parameter int T_W0_LOW    = 60,
  parameter int T_W1_LOW    = 6,
  parameter int T_RD_SMP    = 15,
  parameter int T_SLOT      = 60,
  parameter int T_REC       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  slotReq_t         req,
  input  logic             busIn,
  output logic             busLow,
  output slotEvt_t         evt
);

  localparam int RST_SMP = T_RST_LOW + T_PRES_SMP;
  localparam int RST_END = RST_SMP + T_RST_WAIT;
  localparam int BIT_END = T_SLOT + T_REC;
  localparam int US_W    = $clog2(RST_END + 1);

  logic [SYNC_STAGES-1:0] syncQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= busIn;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= 1'b1;
        else       syncQ[s] <= syncQ[s-1];
    end
  end

  logic            busy;
  slotKind_e       kind;
  logic [US_W-1:0] usCnt;
  logic [DIV_W-1:0] divCnt;
  logic [US_W-1:0] lowLim, smpAt, lastAt;
  logic            tick;

  always_comb begin
    case (kind)
      SLOT_RST: begin
        lowLim = US_W'(T_RST_LOW);
        smpAt  = US_W'(RST_SMP - 1);
        lastAt = US_W'(RST_END - 1);
      end
      SLOT_W0: begin
        lowLim = US_W'(T_W0_LOW);
        smpAt  = US_W'(T_RD_SMP - 1);
        lastAt = US_W'(BIT_END - 1);
      end
      default: begin
        lowLim = US_W'(T_W1_LOW);
        smpAt  = US_W'(T_RD_SMP - 1);
        lastAt = US_W'(BIT_END - 1);
      end
    endcase
  end

  assign tick = busy && (divCnt == divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      kind   <= SLOT_W1;
      usCnt  <= '0;
      divCnt <= '0;
    end else if (req.start && !busy) begin
      busy   <= 1'b1;
      kind   <= req.kind;
      usCnt  <= '0;
      divCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        usCnt  <= usCnt + 1'b1;
        if (usCnt == lastAt) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busLow     = busy && (usCnt < lowLim);
  assign evt.busy   = busy;
  assign evt.smp    = tick && (usCnt == smpAt);
  assign evt.smpBit = syncQ[SYNC_STAGES-1];
  assign evt.done   = tick && (usCnt == lastAt);

endmodule

// File: rtl/owm_ctrl.sv
`timescale 1ns/1ps
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int DIV_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int DIV_INIT = 99
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  slotEvt_t         evt,
  output slotReq_t         req,
  output logic [DIV_W-1:0] divVal
);

  localparam int BC_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  divReg;
  logic              cmdRst, cmdW0, cmdW1, presence, rdBit, lastSmp;
  slotKind_e         curKind;
  logic [BYTE_W-1:0] txBuf, txShift, rxShift, rxBuf, newByte;
  logic              tbe, tsre, rbf, rsrf, byteActive;
  logic [BC_W-1:0]   bitCnt;

  logic      ctrlWr, dataWr, dataRd, cmdOn, cmdHit;
  logic      ctrlStart, bitStart, loadByte;
  slotKind_e ctrlKind;

  always_comb begin
    ctrlWr   = regWe && (regAddr == ADDR_CTRL);
    dataWr   = regWe && (regAddr == ADDR_DATA);
    dataRd   = regRe && (regAddr == ADDR_DATA);
    cmdOn    = cmdRst || cmdW0 || cmdW1;
    cmdHit   = regWdata[CB_RST] || regWdata[CB_W0] || regWdata[CB_W1];
    ctrlKind = regWdata[CB_RST] ? SLOT_RST : (regWdata[CB_W0] ? SLOT_W0 : SLOT_W1);
    ctrlStart = ctrlWr && cmdHit && !evt.busy && !byteActive && !cmdOn;
    bitStart  = byteActive && !evt.busy;
    loadByte  = !byteActive && !tbe && !rsrf && !evt.busy && !cmdOn && !ctrlStart;
    req.start = ctrlStart || bitStart;
    req.kind  = bitStart ? (txShift[0] ? SLOT_W1 : SLOT_W0) : ctrlKind;
    newByte   = {lastSmp, rxShift[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(DIV_INIT);
      {cmdRst, cmdW0, cmdW1, presence, rdBit, lastSmp} <= '0;
      curKind <= SLOT_W1;
      txBuf <= '0; txShift <= '0; rxShift <= '0; rxBuf <= '0;
      tbe <= 1'b1; tsre <= 1'b1; rbf <= 1'b0; rsrf <= 1'b0;
      byteActive <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (regWe && regAddr == ADDR_DIV) divReg <= regWdata[DIV_W-1:0];

      if (ctrlStart) begin
        curKind <= ctrlKind;
        cmdRst  <= (ctrlKind == SLOT_RST);
        cmdW0   <= (ctrlKind == SLOT_W0);
        cmdW1   <= (ctrlKind == SLOT_W1);
      end
      if (bitStart) curKind <= req.kind;

      if (evt.smp) begin
        lastSmp <= evt.smpBit;
        if (curKind == SLOT_RST) presence <= !evt.smpBit;
        if (curKind == SLOT_W1)  rdBit    <= evt.smpBit;
      end

      if (dataRd) begin
        if (rsrf) begin
          rxBuf <= rxShift;
          rsrf  <= 1'b0;
        end else begin
          rbf <= 1'b0;
        end
      end

      if (evt.done) begin
        {cmdRst, cmdW0, cmdW1} <= '0;
        if (byteActive) begin
          rxShift <= newByte;
          txShift <= txShift >> 1;
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == BC_W'(BYTE_W - 1)) begin
            byteActive <= 1'b0;
            tsre       <= tbe;
            if (!rbf || (dataRd && !rsrf)) begin
              rxBuf <= newByte;
              rbf   <= 1'b1;
            end else begin
              rsrf <= 1'b1;
            end
          end
        end
      end

      if (loadByte) begin
        txShift    <= txBuf;
        tbe        <= 1'b1;
        tsre       <= 1'b0;
        byteActive <= 1'b1;
        bitCnt     <= '0;
      end

      if (dataWr && tbe) begin
        txBuf <= regWdata[BYTE_W-1:0];
        tbe   <= 1'b0;
        tsre  <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[CB_RST]   = cmdRst;
        regRdata[CB_PRES]  = presence;
        regRdata[CB_W0]    = cmdW0;
        regRdata[CB_W1]    = cmdW1;
        regRdata[CB_RDBIT] = rdBit;
      end
      ADDR_DIV:  regRdata = REG_W'(divReg);
      ADDR_DATA: regRdata[BYTE_W-1:0] = rxBuf;
      default: begin
        regRdata[SB_TBE]  = tbe;
        regRdata[SB_TSRE] = tsre;
        regRdata[SB_RBF]  = rbf;
        regRdata[SB_RSRF] = rsrf;
      end
    endcase
  end

  assign divVal = divReg;

endmodule

// File: rtl/owm_master.sv
`timescale 1ns/1ps
module owm_master
  import owm_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int DIV_W    = 16,
  parameter int DIV_INIT = 99
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             busIn,
  output logic             busLow
);

  slotReq_t         req;
  slotEvt_t         evt;
  logic [DIV_W-1:0] divVal;

  owm_ctrl #(
    .REG_W(REG_W), .DIV_W(DIV_W), .BYTE_W(8), .DIV_INIT(DIV_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .evt(evt), .req(req), .divVal(divVal)
  );

  owm_slot_engine #(.DIV_W(DIV_W)) u_engine (
    .clk(clk), .rstN(rstN), .divVal(divVal), .req(req),
    .busIn(busIn), .busLow(busLow), .evt(evt)
  );

endmodule

// File: rtl/owm_master_chk.sv
`timescale 1ns/1ps
module owm_master_chk
  import owm_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     busLow,
  input slotReq_t req,
  input slotEvt_t evt
);

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    req.start |-> !evt.busy);

  // R12
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busLow |-> evt.busy);

  // R12
  drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    req.start |=> busLow);

  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.done |-> !busLow);

  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.done |=> !evt.busy);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.busy && !evt.done) |=> evt.busy);

endmodule

bind owm_master owm_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busLow(busLow), .req(req), .evt(evt)
);

// File: tb/sim_owm_master.sv
`timescale 1ns/1ps
module sim_owm_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        busIn, busLow, slaveLow;

  int nChk = 0, nFail = 0;
  int nDiv = 100;

  // bench slave model state
  logic        rxArm = 1'b0, presentMode = 1'b0, prevLow = 1'b0;
  logic [7:0]  rxPat = 8'hFF;
  logic [31:0] wrBits = '0;
  int slaveHold = 0, presDelay = 0, presHold = 0, lowLen = 0, slotCnt = 0;

  always #4 clk = ~clk;

  owm_master u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busIn(busIn), .busLow(busLow)
  );

  assign slaveLow = (slaveHold > 0) || (presHold > 0);
  assign busIn = !(busLow || slaveLow);

  always @(posedge clk) begin
    prevLow <= busLow;
    if (slaveHold > 0) slaveHold <= slaveHold - 1;
    if (presDelay > 0) begin
      presDelay <= presDelay - 1;
      if (presDelay == 1) presHold <= 120 * nDiv;
    end else if (presHold > 0) presHold <= presHold - 1;
    if (busLow && !prevLow) begin
      lowLen <= 1;
      if (rxArm) begin
        if (!rxPat[0]) slaveHold <= 30 * nDiv;
        rxPat <= {rxPat[0], rxPat[7:1]};
      end
    end else if (busLow) lowLen <= lowLen + 1;
    if (!busLow && prevLow) begin
      if (lowLen >= 400 * nDiv) begin
        if (presentMode) presDelay <= 20 * nDiv;
      end else begin
        slotCnt <= slotCnt + 1;
        wrBits  <= {(lowLen < 30 * nDiv), wrBits[31:1]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // issue a control command; count low cycles and cycles the command bit stays set
  task automatic runCmd(input logic [15:0] cmd, input logic [15:0] mask,
                        output int lowC, output int busyC);
    logic [15:0] v;
    lowC = 0; busyC = 0;
    regWrite(2'd0, cmd);
    for (int k = 0; k < 100000; k++) begin
      peek(2'd0, v);
      if (busLow) lowC++;
      if ((v & mask) == 0) break;
      busyC++;
      @(negedge clk);
    end
  endtask

  task automatic waitStat(input int bitPos);
    logic [15:0] v;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      peek(2'd3, v);
      if (v[bitPos]) break;
    end
  endtask

  // {tx byte, slave pattern}; expected read = tx & pattern, expected sent = tx
  localparam logic [15:0] VEC [6] = '{16'hA5FF, 16'h3CFF, 16'hFF5A,
                                      16'hFF00, 16'h0FF0, 16'h81C3};

  initial begin
    #(190000 * 8);
    nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    int lowC, busyC, s0;

    repeat (3) @(negedge clk);
    peek(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    peek(2'd3, v); chk("R1 status", v, 16'h000C);
    peek(2'd1, v); chk("R1 divider", v, 16'd99);
    chk("R1 busLow", busLow, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    peek(2'd0, v); chk("R1 ctrl after release", v, 16'h0000);

    regWrite(2'd1, 16'd1); nDiv = 2;
    peek(2'd1, v); chk("R2 divider readback", v, 16'd1);

    presentMode = 1'b1;
    runCmd(16'h0080, 16'h0080, lowC, busyC);
    chk("R3 reset low cycles", lowC, 480 * 2);
    chk("R3 reset busy cycles", busyC, 960 * 2);
    peek(2'd0, v); chk("R4 presence seen", v, 16'h0040);
    chk("R12 released after reset", busLow, 1'b0);

    presentMode = 1'b0;
    repeat (400) @(negedge clk);
    runCmd(16'h0080, 16'h0080, lowC, busyC);
    peek(2'd0, v); chk("R4 no presence", v, 16'h0000);
    repeat (400) @(negedge clk);

    s0 = slotCnt;
    regWrite(2'd0, 16'h00B0);
    peek(2'd0, v); chk("R7 priority reset wins", v, 16'h0080);
    repeat (20) @(negedge clk);
    regWrite(2'd0, 16'h0010);
    peek(2'd0, v); chk("R7 busy ignores command", v, 16'h0080);
    for (int k = 0; k < 5000; k++) begin
      peek(2'd0, v);
      if (v[7] == 1'b0) break;
      @(negedge clk);
    end
    repeat (200) @(negedge clk);
    peek(2'd0, v); chk("R7 no late slot bit", v, 16'h0000);
    chk("R7 no extra slot", slotCnt - s0, 0);

    runCmd(16'h0020, 16'h0020, lowC, busyC);
    chk("R5 write0 low cycles", lowC, 60 * 2);
    chk("R5 write0 busy cycles", busyC, 70 * 2);
    peek(2'd0, v); chk("R5 self clear", v, 16'h0000);

    rxArm = 1'b1; rxPat = 8'h00;
    runCmd(16'h0010, 16'h0010, lowC, busyC);
    chk("R6 write1 low cycles", lowC, 6 * 2);
    chk("R6 write1 busy cycles", busyC, 70 * 2);
    peek(2'd0, v); chk("R6 read zero", v, 16'h0000);
    rxPat = 8'hFF;
    runCmd(16'h0010, 16'h0010, lowC, busyC);
    peek(2'd0, v); chk("R6 read one", v, 16'h0008);
    rxArm = 1'b0;

    regWrite(2'd1, 16'd4); nDiv = 5;
    runCmd(16'h0020, 16'h0020, lowC, busyC);
    chk("R2 low at N=5", lowC, 60 * 5);
    chk("R2 busy at N=5", busyC, 70 * 5);
    regWrite(2'd1, 16'd1); nDiv = 2;

    foreach (VEC[i]) begin
      rxPat = VEC[i][7:0]; rxArm = 1'b1;
      regWrite(2'd2, {8'h00, VEC[i][15:8]});
      waitStat(4);
      repeat (4) @(negedge clk);
      chk("R8 bits sent lsb first", wrBits[31:24], VEC[i][15:8]);
      regRead(2'd2, v);
      chk("R9 received byte", v, {8'h00, VEC[i][15:8] & VEC[i][7:0]});
      peek(2'd3, v); chk("R10 flags after byte", v, 16'h000C);
      rxArm = 1'b0;
    end

    rxArm = 1'b1; rxPat = 8'hFF; s0 = slotCnt;
    regWrite(2'd2, 16'h0011);
    regWrite(2'd2, 16'h0022);
    peek(2'd3, v); chk("R10 second byte queued", v, 16'h0000);
    regWrite(2'd2, 16'h0033);
    waitStat(5);
    repeat (4) @(negedge clk);
    peek(2'd3, v); chk("R11 both full", v, 16'h003C);
    chk("R10 overflow write dropped", wrBits[31:16], 16'h2211);
    regWrite(2'd2, 16'h0044);
    repeat (400) @(negedge clk);
    chk("R11 held byte blocks next", slotCnt - s0, 16);
    peek(2'd3, v); chk("R11 queued waits", v, 16'h0030);
    regRead(2'd2, v); chk("R11 older byte first", v, 16'h0011);
    peek(2'd3, v); chk("R11 shifter drained", v & 16'h0030, 16'h0010);
    regRead(2'd2, v); chk("R11 held byte next", v, 16'h0022);
    repeat (10) @(negedge clk);
    regWrite(2'd0, 16'h0020);
    peek(2'd0, v); chk("R7 command ignored in byte", v & 16'h00B0, 16'h0000);
    waitStat(4);
    repeat (4) @(negedge clk);
    regRead(2'd2, v); chk("R9 third byte", v, 16'h0044);
    chk("R8 slot total", slotCnt - s0, 24);
    chk("R12 idle release", busLow, 1'b0);
    rxArm = 1'b0;

    finishRun();
  end

endmodule